// File: doc/BRIEF.md
# CRC-32C Multi-Width Accumulate Unit

This block advances a running 32-bit CRC-32C value by one data operand per request. The operand is taken from the low 8, 16, 32 or 64 bits of a 64-bit data input. A 2-bit size code picks the width. The arithmetic uses the generator 0x11EDC6F41 and treats both the data and the CRC in reflected bit order. The unit applies no initial inversion and no final XOR. Software supplies the starting value, so it can add those steps itself.

Each accepted request produces a registered result one clock later. The result is zero-extended to 64 bits. Software builds a CRC over a long message by feeding each result back as the next incoming CRC. A 64-bit operand is allowed only when the request asks for a 64-bit destination. Any other 64-bit request is refused: an error strobe is raised and the previous result is kept.

Top module: `crc32c_accum`

## Requirements
- R1: During and directly after a synchronous active-high reset, `res_valid_o` and `err_o` are 0 and `result_o` is all zeros.
- R2: With `size_i` = 00, the result is the reflected CRC-32C update of `crc_i` over `data_i[7:0]`. The update takes one data bit at a time, starting at bit 0. It shifts the CRC right and XORs in 0x82F63B78 whenever the bit shifted out, XORed with the data bit, is 1. No inversion is applied.
- R3: With `size_i` = 01, the same update runs over `data_i[15:0]`.
- R4: With `size_i` = 10, the same update runs over `data_i[31:0]`.
- R5: With `size_i` = 11 and `dst64_i` = 1, the same update runs over all 64 bits of `data_i`.
- R6: Data bits above the selected width have no effect on the result.
- R7: `result_o[63:32]` is always zero. The CRC sits in `result_o[31:0]` for both destination widths.
- R8: `res_valid_o` is high in exactly the cycle after an accepted request. Requests on consecutive cycles each give a result on consecutive cycles.
- R9: A request with `size_i` = 11 and `dst64_i` = 0 raises `err_o` for one cycle, in the cycle after the request. `res_valid_o` stays low in that cycle and `result_o` keeps its previous value.
- R10: Feeding each result back as `crc_i` gives the same final value as one wide request over the same data. This holds for bytes chained into a 16-, 32- or 64-bit operand.
- R11: In a cycle after no request, `res_valid_o` and `err_o` are 0 and `result_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| crc_i | input | 32 | Incoming CRC value, reflected order |
| data_i | input | 64 | Data operand, low bits used per size |
| size_i | input | 2 | Operand width: 00=8, 01=16, 10=32, 11=64 |
| dst64_i | input | 1 | Request targets a 64-bit destination |
| result_o | output | 64 | Registered result, upper half zero |
| res_valid_o | output | 1 | Result strobe, one cycle after an accepted request |
| err_o | output | 1 | Refused 64-bit request with a 32-bit destination |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path and a 32-bit CRC. With these defaults all four width lanes exist, so every size code reaches a real lane, including the refused 64-bit case. The reference is a bit-serial model that differs from the polynomial long division in the design. It covers all-zero and all-ones operands and data with junk above the selected width. It also checks byte chains against 16-, 32- and 64-bit operands, where the design's own output is fed back as the next CRC.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  localparam int CRC_W  = 32;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;

  // Full generator including the x^32 term
  localparam logic [CRC_W:0] POLY_FULL = 33'h1_1EDC_6F41;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_B16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B64 = 2'b11
  } size_e;

endpackage

// File: rtl/crc_lane.sv
// One fixed-width lane: reflect, align, divide, reflect back.
module crc_lane #(
  parameter int SRC_W = 8,
  parameter int CRC_W = crc32c_pkg::CRC_W,
  parameter logic [CRC_W:0] POLY = crc32c_pkg::POLY_FULL
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [CRC_W-1:0] crc_o
);

  localparam int TOT = SRC_W + CRC_W;

  // Modulo-2 remainder of a TOT-bit dividend by POLY
  function automatic logic [CRC_W-1:0] mod2_rem(input logic [TOT-1:0] v);
    logic [TOT-1:0] r;
    r = v;
    for (int i = TOT - 1; i >= CRC_W; i--) begin
      if (r[i]) r = r ^ (TOT'(POLY) << (i - CRC_W));
    end
    return r[CRC_W-1:0];
  endfunction

  logic [SRC_W-1:0] refl_src;
  logic [CRC_W-1:0] refl_crc;
  logic [CRC_W-1:0] rem;
  logic [TOT-1:0]   dividend;

  always_comb begin
    for (int i = 0; i < SRC_W; i++) refl_src[i] = src_i[SRC_W-1-i];
    for (int i = 0; i < CRC_W; i++) refl_crc[i] = crc_i[CRC_W-1-i];
    dividend = {refl_src, {CRC_W{1'b0}}} ^ (TOT'(refl_crc) << SRC_W);
    rem      = mod2_rem(dividend);
    for (int i = 0; i < CRC_W; i++) crc_o[i] = rem[CRC_W-1-i];
  end

endmodule

// File: rtl/crc_size_mux.sv
// Picks the lane whose width matches the size code.
module crc_size_mux #(
  parameter int N_LANE = 4,
  parameter int CRC_W  = 32,
  parameter int SIZE_W = 2
) (
  input  logic [N_LANE-1:0][CRC_W-1:0] lane_i,
  input  logic [SIZE_W-1:0]            size_i,
  output logic [CRC_W-1:0]             crc_o
);

  assign crc_o = lane_i[size_i];

endmodule

// File: rtl/crc_req_gate.sv
// Splits a request into accepted or refused.
module crc_req_gate #(
  parameter int SIZE_W = 2
) (
  input  logic              valid_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wide_dst_i,
  output logic              accept_o,
  output logic              reject_o
);

  logic widest;
  logic legal;

  assign widest   = (size_i == {SIZE_W{1'b1}});
  assign legal    = !widest || wide_dst_i;
  assign accept_o = valid_i && legal;
  assign reject_o = valid_i && !legal;

endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum #(
  parameter int CRC_W  = crc32c_pkg::CRC_W,
  parameter int DATA_W = crc32c_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              dst64_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_valid_o,
  output logic              err_o
);

  localparam int N_LANE = $clog2(DATA_W / crc32c_pkg::BYTE_W) + 1;
  localparam int SIZE_W = $clog2(N_LANE);
  localparam int PAD_W  = DATA_W - CRC_W;

  logic [N_LANE-1:0][CRC_W-1:0] lane_crc;
  logic [CRC_W-1:0]             sel_crc;
  logic                         accept;
  logic                         reject;

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    localparam int LW = crc32c_pkg::BYTE_W << k;
    crc_lane #(.SRC_W(LW), .CRC_W(CRC_W)) u_lane (
      .crc_i (crc_i),
      .src_i (data_i[LW-1:0]),
      .crc_o (lane_crc[k])
    );
  end

  crc_size_mux #(.N_LANE(N_LANE), .CRC_W(CRC_W), .SIZE_W(SIZE_W)) u_mux (
    .lane_i (lane_crc),
    .size_i (size_i[SIZE_W-1:0]),
    .crc_o  (sel_crc)
  );

  crc_req_gate #(.SIZE_W(SIZE_W)) u_gate (
    .valid_i    (valid_i),
    .size_i     (size_i[SIZE_W-1:0]),
    .wide_dst_i (dst64_i),
    .accept_o   (accept),
    .reject_o   (reject)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      err_o       <= 1'b0;
      result_o    <= '0;
    end else begin
      res_valid_o <= accept;
      err_o       <= reject;
      if (accept) result_o <= {{PAD_W{1'b0}}, sel_crc};
    end
  end

  // R8: accepted request gives a result next cycle
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid_o);
  // R8 / R11: no result strobe without an accepted request
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !res_valid_o);
  // R9: refused request flags error and no result
  p_reject_r9: assert property (@(posedge clk) disable iff (rst)
    reject |=> (err_o && !res_valid_o));
  // R9 / R11: result holds unless a request was accepted
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(result_o));
  // R7: upper half never carries data
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    result_o[DATA_W-1:CRC_W] == '0);
  // R9: error and result strobes are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(err_o && res_valid_o));

endmodule

// File: tb/test_crc32c_accum.sv
module test_crc32c_accum;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] crc_i = '0;
  logic [63:0] data_i = '0;
  logic [1:0]  size_i = '0;
  logic        dst64_i = 1'b0;
  logic [63:0] result_o;
  logic        res_valid_o;
  logic        err_o;

  always #5 clk = ~clk;

  crc32c_accum i_crc32c_accum (
    .clk(clk), .rst(rst), .valid_i(valid_i), .crc_i(crc_i), .data_i(data_i),
    .size_i(size_i), .dst64_i(dst64_i), .result_o(result_o),
    .res_valid_o(res_valid_o), .err_o(err_o)
  );

  typedef struct {
    string       tag;
    bit          is_err;
    logic [63:0] res;
  } item_t;

  item_t       q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [63:0] held = '0;

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [63:0] d, int n);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = c[0] ^ d[i];
      c = c >> 1;
      if (b) c = c ^ 32'h82F6_3B78;
    end
    return c;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(logic [31:0] c, logic [63:0] d, logic [1:0] sz, logic d64, string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; crc_i = c; data_i = d; size_i = sz; dst64_i = d64;
    it.tag = tag;
    it.is_err = (sz == 2'b11) && !d64;
    it.res = it.is_err ? 64'h0 : {32'h0, ref_crc(c, d, 8 << sz)};
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          if (it.is_err) begin
            check({it.tag, " strobes"}, {62'h0, err_o, res_valid_o}, 64'h2);
            check({it.tag, " held result"}, result_o, held);
          end else begin
            check({it.tag, " strobes"}, {62'h0, err_o, res_valid_o}, 64'h1);
            check({it.tag, " result"}, result_o, it.res);
            check({it.tag, " R7 upper"}, {32'h0, result_o[63:32]}, 64'h0);
            held = it.res;
          end
        end else begin
          check("R11 idle strobes", {62'h0, err_o, res_valid_o}, 64'h0);
          check("R11 idle hold", result_o, held);
        end
      end
    end
  end

  task automatic chain(logic [31:0] c0, logic [63:0] d, logic [1:0] sz);
    logic [31:0] c;
    int nb;
    c = c0;
    nb = 1 << sz;
    for (int b = 0; b < nb; b++) begin
      req(c, {56'hA5A5_5A5A_C3C3_3C, d[8*b +: 8]}, 2'b00, 1'b0, "R10 chain byte");
      @(posedge clk);
      #3;
      c = result_o[31:0];
    end
    req(c0, d, sz, 1'b1, "R10 wide");
    @(posedge clk);
    #3;
    check("R10 chained vs wide", result_o, {32'h0, c});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset strobes", {62'h0, err_o, res_valid_o}, 64'h0);
    check("R1 reset result", result_o, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check("R1 after reset", {err_o, res_valid_o, result_o}, 66'h0);

    // R2 byte patterns
    req(32'h0000_0000, 64'h0, 2'b00, 1'b0, "R2 zeros");
    req(32'hFFFF_FFFF, 64'hFF, 2'b00, 1'b0, "R2 ones");
    req(32'h1234_5678, 64'h31, 2'b00, 1'b1, "R2 misc d64");
    // R3 / R4 / R5
    req(32'hFFFF_FFFF, 64'hFFFF, 2'b01, 1'b0, "R3 ones");
    req(32'hCAFE_F00D, 64'h8001, 2'b01, 1'b0, "R3 misc");
    req(32'h0, 64'h0, 2'b10, 1'b0, "R4 zeros");
    req(32'hFFFF_FFFF, 64'hFFFF_FFFF, 2'b10, 1'b0, "R4 ones");
    req(32'h0BAD_CAFE, 64'h1357_9BDF, 2'b10, 1'b1, "R4 misc");
    req(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, "R5 ones");
    req(32'h8000_0001, 64'h0123_4567_89AB_CDEF, 2'b11, 1'b1, "R5 misc");
    req(32'h0, 64'h0, 2'b11, 1'b1, "R5 zeros");
    idle(2);

    // R6 junk above selected width
    req(32'h5555_AAAA, 64'hFFFF_FFFF_FFFF_FF3C, 2'b00, 1'b0, "R6 byte junk");
    req(32'h5555_AAAA, 64'h1234_5678_9ABC_0F0F, 2'b01, 1'b0, "R6 half junk");
    req(32'h5555_AAAA, 64'hFEED_FACE_0000_00FF, 2'b10, 1'b0, "R6 word junk");
    idle(1);

    // R9 refused request, then a legal one right behind it
    req(32'h1111_2222, 64'h0123_4567_89AB_CDEF, 2'b11, 1'b0, "R9 refused");
    req(32'h3333_4444, 64'h77, 2'b00, 1'b0, "R8 after refuse");
    req(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0, "R9 refused ones");
    idle(3);

    // R10 chaining
    chain(32'hFFFF_FFFF, 64'h0000_0000_0000_3231, 2'b01);
    chain(32'h0000_0000, 64'h0000_0000_3433_3231, 2'b10);
    chain(32'hFFFF_FFFF, 64'h3837_3635_3433_3231, 2'b11);
    chain(32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule